// File: doc/BRIEF.md
# Drift-Compensated PTP Time Counter

This block keeps a 64-bit nanosecond time-of-day value for precision time-protocol timestamping. It does not count reference-clock cycles directly. On every edge of the reference clock, a 32-bit fractional phase accumulator adds a programmable addend. Each carry out of that accumulator moves the time value forward by a programmed whole-nanosecond period.

Software picks the addend as the ceiling of 2^32 divided by the ratio of reference frequency to nominal frequency. That ratio is above 1.0, so the addend stays below 2^32 and carries occur on only a fraction of the edges. Small changes to the addend retune the effective rate in parts-per-billion steps. For example, with a 10 ns period, an addend of 0x999999A4 carries on six edges out of ten.

A single write port sets the addend, the period and a 2-bit reference-source code, and it loads the counter. The time value is always visible on a read port. A one-cycle tick output marks every advance, for downstream pulse logic. The reference-source field is only stored and presented; it switches no clock.

Top module: `ptp_time_counter`

## Requirements
- R1: While reset is asserted, `time_o` is 0 and `tick_o` is 0.
- R2: On each clock edge without a load, the block forms the 33-bit sum of the accumulator and the addend. The accumulator takes the low 32 bits. If bit 32 is set, `time_o` grows by the period, modulo 2^64. If bit 32 is clear, `time_o` holds.
- R3: `tick_o` is 1 in exactly those cycles whose `time_o` value came from an advancing edge, and 0 in all other cycles.
- R4: An addend write (`wr_sel_i` = 0, value in `wr_data_i[31:0]`) is used from the edge after the write edge. The write edge itself still uses the old addend. The write leaves the time value and the accumulator undisturbed.
- R5: A period write (`wr_sel_i` = 1, value in `wr_data_i[7:0]`, in nanoseconds) is used from the edge after the write edge, with the same timing as R4.
- R6: A load (`wr_sel_i` = 3) sets `time_o` to `wr_data_i` at that edge. It suppresses that edge's increment and tick, and it clears the accumulator to 0.
- R7: A reference-source write (`wr_sel_i` = 2, code in `wr_data_i[1:0]`) appears on `cksrc_o` after that edge. The codes are 0 external precision clock, 1 system clock, 2 alternate interface clock, 3 RTC oscillator. After reset the code is 1. No other write changes the code.
- R8: Reset sets the addend to all ones and the period to 10 ns. The first edge after reset does not advance the time value. Each following edge advances it until the block is reconfigured.
- R9: After a load with a constant addend A and period P, the time value after N edges equals the loaded value plus P times floor(N·A / 2^32).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe |
| wr_sel_i | input | 2 | Write target: 0 addend, 1 period, 2 reference source, 3 counter load |
| wr_data_i | input | 64 | Write data |
| time_o | output | 64 | Current nanosecond time value |
| tick_o | output | 1 | One-cycle pulse marking an advance |
| cksrc_o | output | 2 | Stored reference-source code |

## Verification
The addend is tried with four kinds of value:
- All ones, after reset, which shows that the first edge is skipped.
- 0x80000000, whose alternating carries show the 33-bit overflow test and the tick alignment.
- Zero, which shows a complete stall and that the write does not disturb the time value.
- 0x999999A4 over 1000 edges from a load, where the closed-form carry count would expose a wrong accumulator width or a reset-to-nonzero.

Directed loads land on an edge that would have carried, which shows that the load takes priority. Period and addend writes are placed next to carries, which shows which edge picks them up. A long random mix of writes and loads, compared against a bench model every cycle, covers the interleavings.

// File: rtl/ptp_tc_pkg.sv
package ptp_tc_pkg;
  typedef enum logic [1:0] {
    CKSRC_EXT = 2'd0,
    CKSRC_SYS = 2'd1,
    CKSRC_ALT = 2'd2,
    CKSRC_RTC = 2'd3
  } cksrc_e;

  typedef enum logic [1:0] {
    WR_ADDEND = 2'd0,
    WR_PERIOD = 2'd1,
    WR_CKSRC  = 2'd2,
    WR_LOAD   = 2'd3
  } wr_sel_e;
endpackage

// File: rtl/ptp_cfg_regs.sv
module ptp_cfg_regs
  import ptp_tc_pkg::*;
#(
  parameter int FRAC_W     = 32,
  parameter int PERIOD_W   = 8,
  parameter int DATA_W     = 64,
  parameter int DEF_PERIOD = 10
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [1:0]          wr_sel_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  output logic [FRAC_W-1:0]   addend_o,
  output logic [PERIOD_W-1:0] period_o,
  output logic [1:0]          cksrc_o,
  output logic                load_o,
  output logic [DATA_W-1:0]   load_val_o
);
  logic [FRAC_W-1:0]   addend_q;
  logic [PERIOD_W-1:0] period_q;
  cksrc_e              cksrc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addend_q <= '1;
      period_q <= PERIOD_W'(DEF_PERIOD);
      cksrc_q  <= CKSRC_SYS;
    end else if (wr_en_i) begin
      unique case (wr_sel_e'(wr_sel_i))
        WR_ADDEND: addend_q <= wr_data_i[FRAC_W-1:0];
        WR_PERIOD: period_q <= wr_data_i[PERIOD_W-1:0];
        WR_CKSRC:  cksrc_q  <= cksrc_e'(wr_data_i[1:0]);
        default:   ;
      endcase
    end
  end

  assign addend_o   = addend_q;
  assign period_o   = period_q;
  assign cksrc_o    = cksrc_q;
  assign load_o     = wr_en_i && (wr_sel_i == WR_LOAD);
  assign load_val_o = wr_data_i;

  // R7: only a reference-source write moves the code
  p_cksrc_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && wr_sel_i == WR_CKSRC) |=> $stable(cksrc_o));
  // R4: addend changes only through its own write
  p_addend_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && wr_sel_i == WR_ADDEND) |=> $stable(addend_o));
endmodule

// File: rtl/ptp_phase_accum.sv
module ptp_phase_accum #(
  parameter int FRAC_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FRAC_W-1:0] addend_i,
  input  logic              clear_i,
  output logic              carry_o
);
  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W:0]   sum;

  assign sum     = {1'b0, acc_q} + {1'b0, addend_i};
  assign carry_o = sum[FRAC_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      acc_q <= '0;
    else if (clear_i) acc_q <= '0;
    else              acc_q <= sum[FRAC_W-1:0];
  end

  // R6: a load leaves the fraction at zero
  p_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> acc_q == '0);
  // R2: a zero addend can never carry out of a zero fraction
  p_zero_add_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_q == '0 && addend_i == '0) |-> !carry_o);
endmodule

// File: rtl/ptp_ns_counter.sv
module ptp_ns_counter #(
  parameter int TIME_W   = 64,
  parameter int PERIOD_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [TIME_W-1:0]   load_val_i,
  input  logic                step_i,
  input  logic [PERIOD_W-1:0] period_i,
  output logic [TIME_W-1:0]   time_o,
  output logic                tick_o
);
  logic [TIME_W-1:0] time_q;
  logic              tick_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      time_q <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= step_i && !load_i;
      if (load_i)      time_q <= load_val_i;
      else if (step_i) time_q <= time_q + TIME_W'(period_i);
    end
  end

  assign time_o = time_q;
  assign tick_o = tick_q;

  p_advance_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i) |=> time_o == $past(time_o) + TIME_W'($past(period_i)));
  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !load_i) |=> $stable(time_o) && !tick_o);
  p_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> time_o == $past(load_val_i) && !tick_o);
  p_tick_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> time_o == $past(time_o) + TIME_W'($past(period_i)));
endmodule

// File: rtl/ptp_time_counter.sv
module ptp_time_counter #(
  parameter int TIME_W     = 64,
  parameter int FRAC_W     = 32,
  parameter int PERIOD_W   = 8,
  parameter int DEF_PERIOD = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [TIME_W-1:0] wr_data_i,
  output logic [TIME_W-1:0] time_o,
  output logic              tick_o,
  output logic [1:0]        cksrc_o
);
  logic [FRAC_W-1:0]   addend;
  logic [PERIOD_W-1:0] period;
  logic                load;
  logic [TIME_W-1:0]   load_val;
  logic                carry;

  ptp_cfg_regs #(
    .FRAC_W(FRAC_W), .PERIOD_W(PERIOD_W), .DATA_W(TIME_W), .DEF_PERIOD(DEF_PERIOD)
  ) u_cfg (
    .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_data_i,
    .addend_o(addend), .period_o(period), .cksrc_o,
    .load_o(load), .load_val_o(load_val)
  );

  ptp_phase_accum #(.FRAC_W(FRAC_W)) u_acc (
    .clk_i, .rst_ni, .addend_i(addend), .clear_i(load), .carry_o(carry)
  );

  ptp_ns_counter #(.TIME_W(TIME_W), .PERIOD_W(PERIOD_W)) u_cnt (
    .clk_i, .rst_ni, .load_i(load), .load_val_i(load_val),
    .step_i(carry), .period_i(period), .time_o, .tick_o
  );
endmodule

// File: tb/tb_ptp_time_counter.sv
`timescale 1ns/1ps
module tb_ptp_time_counter;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [63:0] wr_data = '0;
  logic [63:0] time_o;
  logic        tick_o;
  logic [1:0]  cksrc_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // bench model state
  logic [63:0] m_time;
  logic [31:0] m_acc, m_add;
  logic [7:0]  m_per;
  logic [1:0]  m_cks;
  logic        m_tick;

  always #4 clk = ~clk;

  ptp_time_counter dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .time_o(time_o), .tick_o(tick_o), .cksrc_o(cksrc_o)
  );

  function automatic logic [63:0] run_advance(logic [31:0] a, logic [7:0] p, int n);
    logic [95:0] prod = 96'(n) * 96'(a);
    return 64'(prod >> 32) * 64'(p);
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_time = '0; m_acc = '0; m_add = '1; m_per = 8'd10; m_cks = 2'd1; m_tick = 1'b0;
  endtask

  task automatic model_edge(bit en, logic [1:0] sel, logic [63:0] d);
    logic [32:0] s;
    if (en && sel == 2'd3) begin
      m_time = d; m_acc = '0; m_tick = 1'b0;
    end else begin
      s = {1'b0, m_acc} + {1'b0, m_add};
      m_acc = s[31:0];
      m_tick = s[32];
      if (s[32]) m_time = m_time + 64'(m_per);
    end
    if (en) begin
      case (sel)
        2'd0: m_add = d[31:0];
        2'd1: m_per = d[7:0];
        2'd2: m_cks = d[1:0];
        default: ;
      endcase
    end
  endtask

  // drive at negedge, model the edge, compare at the next negedge
  task automatic step(bit en, logic [1:0] sel, logic [63:0] d, string tag);
    wr_en = en; wr_sel = sel; wr_data = d;
    @(posedge clk);
    model_edge(en, sel, d);
    @(negedge clk);
    wr_en = 1'b0;
    chk({tag, " R2 time"}, time_o, m_time);
    chk({tag, " R3 tick"}, 64'(tick_o), 64'(m_tick));
    chk({tag, " R7 cksrc"}, 64'(cksrc_o), 64'(m_cks));
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) step(1'b0, 2'd0, '0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] base;
    void'($urandom(32'd4242));
    model_reset();
    repeat (3) @(negedge clk);
    chk("R1 reset time", time_o, 64'd0);
    chk("R1 reset tick", 64'(tick_o), 64'd0);
    chk("R7 reset cksrc", 64'(cksrc_o), 64'd1);
    rst_ni = 1'b1;

    // R8: all-ones addend skips the first edge, then advances each edge
    step(1'b0, 2'd0, '0, "R8 first");
    chk("R8 first edge no advance", time_o, 64'd0);
    step(1'b0, 2'd0, '0, "R8 second");
    chk("R8 second edge advance", time_o, 64'd10);
    idle(5, "R8 run");
    chk("R8 advance each edge", time_o, 64'd60);

    // R6: load, then a load on an edge that would carry
    step(1'b1, 2'd3, 64'd1000, "R6 load");
    chk("R6 load value", time_o, 64'd1000);
    chk("R6 load tick", 64'(tick_o), 64'd0);
    step(1'b0, 2'd0, '0, "R6 pre");
    step(1'b1, 2'd3, 64'h1234_5678_9abc_def0, "R6 load over carry");
    chk("R6 load beats carry", time_o, 64'h1234_5678_9abc_def0);

    // R4: addend write edge uses the old addend
    step(1'b1, 2'd0, 64'h8000_0000, "R4 write half");
    chk("R4 write edge uses old addend", time_o, 64'h1234_5678_9abc_def0);
    idle(8, "R4 half");
    // R5: period write
    step(1'b1, 2'd1, 64'd25, "R5 write period");
    idle(6, "R5 run");
    // R4: zero addend stalls, time untouched by the write
    step(1'b1, 2'd0, 64'd0, "R4 zero");
    base = time_o;
    idle(20, "R4 stall");
    chk("R4 zero addend holds", time_o, base);

    // R7: every source code
    step(1'b1, 2'd2, 64'd0, "R7 ext");
    chk("R7 code 0", 64'(cksrc_o), 64'd0);
    step(1'b1, 2'd2, 64'd2, "R7 alt");
    step(1'b1, 2'd2, 64'hFFFF_FFFF_FFFF_FFF3, "R7 rtc");
    chk("R7 code 3", 64'(cksrc_o), 64'd3);
    step(1'b1, 2'd3, 64'd7, "R7 load keeps code");
    chk("R7 load keeps code", 64'(cksrc_o), 64'd3);

    // R9: long run from a load
    step(1'b1, 2'd0, 64'h9999_99A4, "R9 addend");
    step(1'b1, 2'd1, 64'd10, "R9 period");
    step(1'b1, 2'd3, 64'd500, "R9 load");
    idle(1000, "R9 run");
    chk("R9 closed-form time", time_o, 64'd500 + run_advance(32'h9999_99A4, 8'd10, 1000));

    // R2 wrap modulo 2^64
    step(1'b1, 2'd0, 64'hFFFF_FFFF, "R2 wrap add");
    step(1'b1, 2'd3, 64'hFFFF_FFFF_FFFF_FFFC, "R2 wrap load");
    idle(3, "R2 wrap");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom_range(0, 99);
      logic [63:0] d = {$urandom, $urandom};
      if (r < 85)      step(1'b0, 2'd0, '0, "R2 rnd idle");
      else if (r < 91) step(1'b1, 2'd0, d, "R4 rnd addend");
      else if (r < 95) step(1'b1, 2'd1, d, "R5 rnd period");
      else if (r < 98) step(1'b1, 2'd2, d, "R7 rnd cksrc");
      else             step(1'b1, 2'd3, d, "R6 rnd load");
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule